// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This block sits between instruction decode and the data-memory port of a small 32-bit load-store processor. For each accepted instruction word it works out which of six memory-class operations is meant. It then forms the effective address and presents, one cycle later, either a memory request or a register write-back value. The caller supplies three inputs: the instruction word, the program counter already advanced past that instruction, and the value read from the base register named by the instruction. Memory, the register file and instruction fetch all live outside the block.

Two address forms exist. The displacement form adds a sign-extended 17-bit constant to a base register. A base field of zero means "no base", so register 0 is never read for addressing and the 17-bit constant is the address on its own. The relative form adds a sign-extended 22-bit constant to the advanced program counter. Loads and stores send the address to memory. The two address-load operations return the address itself as write-back data and do not touch memory. Memory is byte-addressed and holds each word big-endian, so the most significant byte sits at the lowest address. The request carries the byte address of the word's first byte.

Inside, a two-state sequencer governs the registered output stage. ST_IDLE means no result is presented. ST_ISSUE means exactly one captured result is on the outputs. The transitions are:
- T_ACCEPT: ST_IDLE to ST_ISSUE, on a strobe with a memory-class opcode.
- T_REFIRE: ST_ISSUE to ST_ISSUE, on another such strobe.
- T_RETIRE: ST_ISSUE to ST_IDLE, when there is no strobe.
- T_DROP: either state to ST_IDLE, on a strobe with any other opcode.

Top module: `lsa_unit`

## Requirements
- R1: An active-high synchronous reset drives `mem_req`, `mem_we` and `wb_en` low at the next clock edge, even when a strobe is present in the same cycle.
- R2: The instruction word is split as follows: opcode in bits 31..27, target register index in bits 26..22, base register index in bits 21..17, short constant in bits 16..0, long constant in bits 21..0. The target index appears on `dst_idx` whenever a valid flag is high.
- R3: For the displacement form with a base index of zero, the address is the short constant sign-extended from bit 16, and `base_val` has no effect on it.
- R4: For the displacement form with a nonzero base index, the address is `base_val` plus the sign-extended short constant, modulo 2^32.
- R5: For the relative form, the address is `pc_next` plus the long constant sign-extended from bit 21, modulo 2^32.
- R6: Opcode 1 (displacement) and opcode 2 (relative) give `mem_req`=1, `mem_we`=0, `wb_en`=0, with the address on `mem_addr`.
- R7: Opcode 3 (displacement) and opcode 4 (relative) give `mem_req`=1, `mem_we`=1, `wb_en`=0, with the address on `mem_addr`. `dst_idx` names the register that supplies the store data.
- R8: Opcode 5 (displacement) and opcode 6 (relative) give `wb_en`=1 with the address on `wb_data`, and `mem_req`=0, `mem_we`=0.
- R9: A strobe with any opcode other than 1 to 6 raises no valid flag in the following cycle.
- R10: Results appear in the cycle after the strobe edge and last exactly one cycle. Without a new strobe, all valid flags are low in the cycle after that.
- R11: Strobes on consecutive cycles each produce their own result, one per cycle, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: instruction, PC and base value are valid this cycle |
| instr | input | 32 | Instruction word |
| pc_next | input | 32 | Program counter already advanced by 4 |
| base_val | input | 32 | Contents of the register named by bits 21..17 |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write (store) |
| mem_addr | output | 32 | Byte address of the word |
| dst_idx | output | 5 | Register to load, to write back, or to source store data |
| wb_en | output | 1 | Write-back of an address value is valid |
| wb_data | output | 32 | Address value to write back |

## Verification
Every result is due in the single cycle that follows the clock edge at which its strobe is sampled. Every valid flag must be low one cycle later unless a new strobe arrived. The bench drives inputs on the falling edge. It reads the result on the next falling edge, which falls inside the result cycle, and withdraws the strobe at that same time. Then, for R10, it reads once more a full cycle later to check that the flags have cleared. Back-to-back strobes are read on successive falling edges. A strobe given together with reset is read at the first falling edge after that edge.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    localparam int WORD_W  = 32;
    localparam int OPC_W   = 5;
    localparam int RIDX_W  = 5;
    localparam int SHORT_W = 17;
    localparam int LONG_W  = 22;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_ADDR  = 2'd3
    } acc_kind_e;

    localparam logic [OPC_W-1:0] OPC_LD_DSP = 5'd1;
    localparam logic [OPC_W-1:0] OPC_LD_REL = 5'd2;
    localparam logic [OPC_W-1:0] OPC_ST_DSP = 5'd3;
    localparam logic [OPC_W-1:0] OPC_ST_REL = 5'd4;
    localparam logic [OPC_W-1:0] OPC_LA_DSP = 5'd5;
    localparam logic [OPC_W-1:0] OPC_LA_REL = 5'd6;
endpackage

// File: rtl/lsa_decode.sv
module lsa_decode
    import lsa_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int OW = OPC_W,
    parameter int RW = RIDX_W,
    parameter int SW = SHORT_W,
    parameter int LW = LONG_W
) (
    input  logic [W-1:0]  instr,
    output acc_kind_e     kind,
    output logic          use_rel,
    output logic [RW-1:0] ra_idx,
    output logic [RW-1:0] rb_idx,
    output logic [W-1:0]  short_sx,
    output logic [W-1:0]  long_sx
);
    localparam int OP_LSB = W - OW;
    localparam int RA_LSB = OP_LSB - RW;

    logic [OW-1:0] opcode;

    assign opcode = instr[W-1 -: OW];
    assign ra_idx = instr[OP_LSB-1 -: RW];
    assign rb_idx = instr[RA_LSB-1 -: RW];

    // Constant widening: sign-extend when the word is wider than the field.
    generate
        if (W > SW) begin : g_short_ext
            assign short_sx = {{(W-SW){instr[SW-1]}}, instr[SW-1:0]};
        end else begin : g_short_cut
            assign short_sx = instr[W-1:0];
        end
        if (W > LW) begin : g_long_ext
            assign long_sx = {{(W-LW){instr[LW-1]}}, instr[LW-1:0]};
        end else begin : g_long_cut
            assign long_sx = instr[W-1:0];
        end
    endgenerate

    // Opcode classification: access kind and address form.
    always_comb begin
        kind    = ACC_NONE;
        use_rel = 1'b0;
        unique case (opcode)
            OPC_LD_DSP: kind = ACC_LOAD;
            OPC_LD_REL: begin kind = ACC_LOAD;  use_rel = 1'b1; end
            OPC_ST_DSP: kind = ACC_STORE;
            OPC_ST_REL: begin kind = ACC_STORE; use_rel = 1'b1; end
            OPC_LA_DSP: kind = ACC_ADDR;
            OPC_LA_REL: begin kind = ACC_ADDR;  use_rel = 1'b1; end
            default: begin
                kind    = ACC_NONE;
                use_rel = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lsa_addr_calc.sv
module lsa_addr_calc #(
    parameter int W  = 32,
    parameter int RW = 5
) (
    input  logic [RW-1:0] rb_idx,
    input  logic          use_rel,
    input  logic [W-1:0]  base_val,
    input  logic [W-1:0]  pc_next,
    input  logic [W-1:0]  short_sx,
    input  logic [W-1:0]  long_sx,
    output logic [W-1:0]  eff_addr
);
    logic          no_base;
    logic [W-1:0]  base_term;
    logic [W-1:0]  disp_addr;
    logic [W-1:0]  rel_addr;

    // Base index zero means absolute: the register value is not used.
    assign no_base   = (rb_idx == '0);
    assign base_term = no_base ? '0 : base_val;
    assign disp_addr = base_term + short_sx;
    assign rel_addr  = pc_next + long_sx;
    assign eff_addr  = use_rel ? rel_addr : disp_addr;
endmodule

// File: rtl/lsa_issue_fsm.sv
module lsa_issue_fsm
    import lsa_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int RW = RIDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  acc_kind_e     kind,
    input  logic [W-1:0]  eff_addr,
    input  logic [RW-1:0] ra_idx,
    output logic          mem_req,
    output logic          mem_we,
    output logic [W-1:0]  mem_addr,
    output logic [RW-1:0] dst_idx,
    output logic          wb_en,
    output logic [W-1:0]  wb_data
);
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } issue_state_e;

    issue_state_e  state, state_nx;
    acc_kind_e     cap_kind;
    logic [W-1:0]  cap_addr;
    logic [RW-1:0] cap_idx;
    logic          take;

    assign take = in_valid && (kind != ACC_NONE);

    // Next-state logic: T_ACCEPT, T_REFIRE, T_RETIRE, T_DROP.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = take ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_nx = take ? ST_ISSUE : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // Capture of one request per accepted strobe.
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_kind <= ACC_NONE;
            cap_addr <= '0;
            cap_idx  <= '0;
        end else if (take) begin
            cap_kind <= kind;
            cap_addr <= eff_addr;
            cap_idx  <= ra_idx;
        end
    end

    // Output process: flags from the state, payload from the captured registers.
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        wb_en    = 1'b0;
        mem_addr = cap_addr;
        wb_data  = cap_addr;
        dst_idx  = cap_idx;
        unique case (state)
            ST_IDLE: begin
                mem_req = 1'b0;
            end
            ST_ISSUE: begin
                mem_req = (cap_kind == ACC_LOAD) || (cap_kind == ACC_STORE);
                mem_we  = (cap_kind == ACC_STORE);
                wb_en   = (cap_kind == ACC_ADDR);
            end
            default: begin
                mem_req = 1'b0;
            end
        endcase
    end

    // R10: with no strobe, nothing is presented next cycle
    a_r10_one_shot: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!mem_req && !wb_en));

    // R9: a strobe with a non-memory opcode produces nothing
    a_r9_drop_other: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind == ACC_NONE) |=> (!mem_req && !wb_en));

    // R11: every memory-class strobe yields a result next cycle
    a_r11_each_strobe: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind != ACC_NONE) |=> (mem_req || wb_en));

    // R8: an address write-back never also requests memory
    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && wb_en));

    // R7: a write is only flagged within a request
    a_r7_we_in_req: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);
endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
    import lsa_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int OW = OPC_W,
    parameter int RW = RIDX_W,
    parameter int SW = SHORT_W,
    parameter int LW = LONG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [W-1:0]  instr,
    input  logic [W-1:0]  pc_next,
    input  logic [W-1:0]  base_val,
    output logic          mem_req,
    output logic          mem_we,
    output logic [W-1:0]  mem_addr,
    output logic [RW-1:0] dst_idx,
    output logic          wb_en,
    output logic [W-1:0]  wb_data
);
    acc_kind_e     kind;
    logic          use_rel;
    logic [RW-1:0] ra_idx;
    logic [RW-1:0] rb_idx;
    logic [W-1:0]  short_sx;
    logic [W-1:0]  long_sx;
    logic [W-1:0]  eff_addr;

    lsa_decode #(.W(W), .OW(OW), .RW(RW), .SW(SW), .LW(LW)) u_dec (
        .instr    (instr),
        .kind     (kind),
        .use_rel  (use_rel),
        .ra_idx   (ra_idx),
        .rb_idx   (rb_idx),
        .short_sx (short_sx),
        .long_sx  (long_sx)
    );

    lsa_addr_calc #(.W(W), .RW(RW)) u_calc (
        .rb_idx   (rb_idx),
        .use_rel  (use_rel),
        .base_val (base_val),
        .pc_next  (pc_next),
        .short_sx (short_sx),
        .long_sx  (long_sx),
        .eff_addr (eff_addr)
    );

    lsa_issue_fsm #(.W(W), .RW(RW)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .kind     (kind),
        .eff_addr (eff_addr),
        .ra_idx   (ra_idx),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .dst_idx  (dst_idx),
        .wb_en    (wb_en),
        .wb_data  (wb_data)
    );

    // R3: absolute displacement addresses lie in the top or bottom 64 KiB
    a_r3_abs_range: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind != ACC_NONE && !use_rel && rb_idx == '0)
        |=> ((mem_addr[W-1:SW-1] == '0) || (mem_addr[W-1:SW-1] == '1)));

    // R2: the index presented is the one carried by the accepted instruction
    a_r2_dst_index: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind != ACC_NONE) |=> (dst_idx == $past(instr[W-OW-1 -: RW])));
endmodule

// File: tb/lsa_unit_tb.sv
module lsa_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] pc_next = '0;
    logic [31:0] base_val = '0;
    logic        mem_req, mem_we, wb_en;
    logic [31:0] mem_addr, wb_data;
    logic [4:0]  dst_idx;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    lsa_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .pc_next(pc_next), .base_val(base_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .dst_idx(dst_idx), .wb_en(wb_en), .wb_data(wb_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ea_of(input logic [4:0] op, input logic [21:0] lo,
                                          input logic [31:0] pc, input logic [31:0] bv);
        logic [31:0] s17, s22, base;
        s17  = {{15{lo[16]}}, lo[16:0]};
        s22  = {{10{lo[21]}}, lo};
        base = (lo[21:17] == 5'd0) ? 32'd0 : bv;
        if (op == 5'd2 || op == 5'd4 || op == 5'd6) return pc + s22;
        return base + s17;
    endfunction

    // Drive one strobe at a falling edge.
    task automatic drive(input logic [4:0] op, input logic [4:0] ra, input logic [21:0] lo,
                         input logic [31:0] pc, input logic [31:0] bv);
        in_valid = 1'b1;
        instr    = {op, ra, lo};
        pc_next  = pc;
        base_val = bv;
    endtask

    // Check the result cycle for a previously driven strobe.
    task automatic expect_res(input logic [4:0] op, input logic [4:0] ra, input logic [21:0] lo,
                              input logic [31:0] pc, input logic [31:0] bv);
        logic [31:0] ea;
        logic is_ld, is_st, is_la;
        ea    = ea_of(op, lo, pc, bv);
        is_ld = (op == 5'd1 || op == 5'd2);
        is_st = (op == 5'd3 || op == 5'd4);
        is_la = (op == 5'd5 || op == 5'd6);
        if (is_ld) begin
            chk("R6 load req", {31'd0, mem_req}, 32'd1);
            chk("R6 load not write", {31'd0, mem_we}, 32'd0);
            chk("R6 load no wb", {31'd0, wb_en}, 32'd0);
            chk(lo[21:17] == 5'd0 && op == 5'd1 ? "R3 load abs addr" :
                (op == 5'd1 ? "R4 load disp addr" : "R5 load rel addr"), mem_addr, ea);
            chk("R2 load dst", {27'd0, dst_idx}, {27'd0, ra});
        end else if (is_st) begin
            chk("R7 store req", {31'd0, mem_req}, 32'd1);
            chk("R7 store write", {31'd0, mem_we}, 32'd1);
            chk("R7 store no wb", {31'd0, wb_en}, 32'd0);
            chk(lo[21:17] == 5'd0 && op == 5'd3 ? "R3 store abs addr" :
                (op == 5'd3 ? "R4 store disp addr" : "R5 store rel addr"), mem_addr, ea);
            chk("R7 store data reg", {27'd0, dst_idx}, {27'd0, ra});
        end else if (is_la) begin
            chk("R8 addr wb", {31'd0, wb_en}, 32'd1);
            chk("R8 addr no req", {31'd0, mem_req}, 32'd0);
            chk("R8 addr no write", {31'd0, mem_we}, 32'd0);
            chk(op == 5'd5 ? "R8 R4 la value" : "R8 R5 lar value", wb_data, ea);
            chk("R2 wb dst", {27'd0, dst_idx}, {27'd0, ra});
        end else begin
            chk("R9 other no req", {31'd0, mem_req}, 32'd0);
            chk("R9 other no wb", {31'd0, wb_en}, 32'd0);
        end
    endtask

    logic [21:0] pat_lo [6];
    logic [31:0] pat_pc [6];
    logic [31:0] pat_bv [6];

    initial begin
        pat_lo[0] = 22'h000010;           pat_bv[0] = 32'hDEAD_BEEF; pat_pc[0] = 32'h0000_1000;
        pat_lo[1] = {5'd3, 17'h0000B};    pat_bv[1] = 32'h0000_0100; pat_pc[1] = 32'h0000_5004;
        pat_lo[2] = {5'd0, 17'h10000};    pat_bv[2] = 32'h1234_5678; pat_pc[2] = 32'h0001_0000;
        pat_lo[3] = {5'd31, 17'h1FFFF};   pat_bv[3] = 32'h8000_0000; pat_pc[3] = 32'h0000_0004;
        pat_lo[4] = 22'h200000;           pat_bv[4] = 32'h0000_0040; pat_pc[4] = 32'h0040_0000;
        pat_lo[5] = {5'd7, 17'h00020};    pat_bv[5] = 32'hFFFF_FFF0; pat_pc[5] = 32'hFFFF_FFFC;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset req", {31'd0, mem_req}, 32'd0);
        chk("R1 reset wb", {31'd0, wb_en}, 32'd0);
        chk("R1 reset we", {31'd0, mem_we}, 32'd0);
        rst = 1'b0;

        // Sweep every opcode over all operand patterns (R2..R10)
        for (int op = 0; op < 32; op++) begin
            for (int p = 0; p < 6; p++) begin
                logic [4:0] ra;
                ra = 5'(op + 7 * p);
                drive(5'(op), ra, pat_lo[p], pat_pc[p], pat_bv[p]);
                @(posedge clk);
                @(negedge clk);
                expect_res(5'(op), ra, pat_lo[p], pat_pc[p], pat_bv[p]);
                in_valid = 1'b0;
                @(posedge clk);
                @(negedge clk);
                chk("R10 one-shot req", {31'd0, mem_req}, 32'd0);
                chk("R10 one-shot wb", {31'd0, wb_en}, 32'd0);
            end
        end

        // R3: base value has no effect when the base index is zero
        drive(5'd1, 5'd9, 22'h000080, 32'h0, 32'hFFFF_0000);
        @(posedge clk); @(negedge clk);
        chk("R3 base ignored", mem_addr, 32'h0000_0080);
        in_valid = 1'b0;
        @(posedge clk); @(negedge clk);

        // R11: back-to-back strobes: load, store, address-load, other, load
        drive(5'd2, 5'd1, 22'h000100, 32'h0000_2000, 32'h0);
        @(posedge clk); @(negedge clk);
        expect_res(5'd2, 5'd1, 22'h000100, 32'h0000_2000, 32'h0);
        drive(5'd3, 5'd2, {5'd4, 17'h1FFFC}, 32'h0, 32'h0000_0010);
        @(posedge clk); @(negedge clk);
        chk("R11 second store addr", mem_addr, 32'h0000_000C);
        expect_res(5'd3, 5'd2, {5'd4, 17'h1FFFC}, 32'h0, 32'h0000_0010);
        drive(5'd6, 5'd3, 22'h3FFFF0, 32'h0000_0100, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R11 third lar value", wb_data, 32'h0000_00F0);
        drive(5'd31, 5'd4, 22'h0, 32'h0, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R11 R9 stop in burst", {30'd0, mem_req, wb_en}, 32'd0);
        drive(5'd1, 5'd5, 22'h000004, 32'h0, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R11 fifth load req", {31'd0, mem_req}, 32'd1);
        chk("R11 fifth addr", mem_addr, 32'h0000_0004);
        in_valid = 1'b0;
        @(posedge clk); @(negedge clk);

        // R1: reset wins over a simultaneous strobe
        drive(5'd5, 5'd6, 22'h000001, 32'h0, 32'h0);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 reset beats strobe req", {31'd0, mem_req}, 32'd0);
        chk("R1 reset beats strobe wb", {31'd0, wb_en}, 32'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(posedge clk); @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule